// File: doc/BRIEF.md
# Single Internal Bus Accumulator Datapath

This block is a small processor datapath in which one shared internal bus connects every register (instruction register, memory address register, memory buffer register, accumulator) and a combinational ALU. Because the ALU holds no state and may never drive the bus itself, an operand latch Y and a result latch Z are placed around it. A step controller walks each instruction through a fixed sequence of one-source bus transfers. In every step it enables exactly one bus driver, raises the load strobes of the destinations and picks the ALU function.

A client presents an instruction word and pulses `start_i`. The upper three bits of the word are the operation code and the lower `AW` bits are a memory address. The block reads or writes an external synchronous memory, updates the accumulator, and raises `done_o` for one cycle when the instruction has completed. A sticky `bus_err_o` flag reports any step in which more than one bus driver was enabled.

Top module: `sbd_top`

## Requirements
- R1: After reset, `ac_o` is 0 and `busy_o`, `done_o`, `bus_err_o`, `mem_rd_o` and `mem_we_o` are all 0.
- R2: Code 0 (add) leaves the accumulator holding (AC + M[addr]) mod 2^DW, where M[addr] is the memory word at the instruction's low `AW` bits.
- R3: Code 1 (subtract) leaves the accumulator holding (AC − M[addr]) mod 2^DW.
- R4: Code 2 leaves the accumulator holding AC AND M[addr]. Code 3 leaves it holding AC OR M[addr].
- R5: Code 4 (load) passes M[addr] through the ALU unchanged into the accumulator.
- R6: Code 5 (store) writes the accumulator value to M[addr] with exactly one `mem_we_o` cycle, issues no read, and leaves the accumulator unchanged.
- R7: Codes 6 and 7 change neither the accumulator nor memory and issue no memory access, but still complete with a `done_o` pulse.
- R8: Counting the cycle in which `start_i` is accepted as cycle 0, `done_o` is high in cycle 7 for codes 0–4, in cycle 4 for code 5, and in cycle 2 for codes 6–7.
- R9: `done_o` lasts exactly one cycle. For codes 0–4 it follows directly the cycle in which the accumulator loads its result.
- R10: `start_i` is accepted only while `busy_o` is 0. A request held or re-issued while an instruction is in flight is ignored.
- R11: At most one bus driver is enabled in any cycle, so `bus_err_o` stays 0.
- R12: Codes 0–4 issue exactly one `mem_rd_o` cycle, with `mem_addr_o` equal to the instruction's address field. Read data is taken one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to execute `instr_i` |
| instr_i | input | 3+AW | Operation code in the upper 3 bits, address in the low AW bits |
| busy_o | output | 1 | An instruction is in flight |
| done_o | output | 1 | One-cycle completion pulse |
| ac_o | output | DW | Accumulator value |
| bus_err_o | output | 1 | Sticky flag for two bus drivers enabled in the same cycle |
| mem_addr_o | output | AW | Memory address (memory address register) |
| mem_rd_o | output | 1 | Synchronous read strobe |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | DW | Write data (memory buffer register) |
| mem_rdata_i | input | DW | Read data, valid the cycle after the read strobe |

## Verification
The completion pulse and a fresh request can land in the same cycle: the controller is still finishing one instruction while `start_i` asks for the next. The bench provokes this by holding `start_i` high through an entire add while it swaps `instr_i` to a store aimed at another address. It drops the request only on the cycle after `done_o`. The case is judged at the ports. There must be one done pulse, `busy_o` must stay low afterwards, the accumulator must hold the add result, the store target must be unchanged, and the read count must rise by exactly one.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  localparam int OPW  = 3;
  localparam int NDRV = 4;

  localparam int DRV_IR  = 0;
  localparam int DRV_MBR = 1;
  localparam int DRV_AC  = 2;
  localparam int DRV_Z   = 3;

  typedef enum logic [OPW-1:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    FN_ADD  = 3'd0,
    FN_SUB  = 3'd1,
    FN_AND  = 3'd2,
    FN_OR   = 3'd3,
    FN_PASS = 3'd4
  } alu_fn_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_READ,
    ST_CAPT,
    ST_OPND,
    ST_CALC,
    ST_WBAC,
    ST_SMBR,
    ST_WRITE,
    ST_DONE
  } step_e;

  typedef struct packed {
    logic [NDRV-1:0] drv;
    logic            ld_ir;
    logic            ld_mar;
    logic            ld_mbr_bus;
    logic            ld_mbr_mem;
    logic            ld_y;
    logic            ld_z;
    logic            ld_ac;
    logic            mem_rd;
    logic            mem_we;
    logic            done;
    logic            busy;
    alu_fn_e         fn;
  } ctrl_t;

endpackage

// File: rtl/sbd_alu.sv
module sbd_alu
  import sbd_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_fn_e         fn,
  input  logic [DW-1:0]   bus_in,
  input  logic [DW-1:0]   y_in,
  output logic [DW-1:0]   res
);

  always_comb begin
    unique case (fn)
      FN_ADD:  res = bus_in + y_in;
      FN_SUB:  res = bus_in - y_in;
      FN_AND:  res = bus_in & y_in;
      FN_OR:   res = bus_in | y_in;
      default: res = y_in;
    endcase
  end

endmodule

// File: rtl/sbd_bus.sv
module sbd_bus
  import sbd_pkg::*;
#(
  parameter int DW = 8,
  parameter int N  = NDRV
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         en,
  input  logic [N-1:0][DW-1:0] src,
  output logic [DW-1:0]        bus,
  output logic                 conflict
);

  logic [N-1:0][DW-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_gate
    assign gated[i] = src[i] & {DW{en[i]}};
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) bus = bus | gated[i];
  end

  assign conflict = ($countones(en) > 1);

  p_single_driver_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en))
    else $error("R11: more than one bus driver enabled");

endmodule

// File: rtl/sbd_ctrl.sv
module sbd_ctrl
  import sbd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  op_e   ir_op,
  output ctrl_t ctl
);

  step_e st_q, st_d;

  function automatic alu_fn_e fn_of(op_e op);
    unique case (op)
      OP_ADD:  return FN_ADD;
      OP_SUB:  return FN_SUB;
      OP_AND:  return FN_AND;
      OP_OR:   return FN_OR;
      default: return FN_PASS;
    endcase
  endfunction

  always_comb begin
    st_d     = st_q;
    ctl      = '0;
    ctl.fn   = FN_PASS;
    ctl.busy = (st_q != ST_IDLE);
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          ctl.ld_ir = 1'b1;
          st_d      = ST_ADDR;
        end
      end
      ST_ADDR: begin
        ctl.drv[DRV_IR] = 1'b1;
        ctl.ld_mar      = 1'b1;
        if (ir_op == OP_STORE)                         st_d = ST_SMBR;
        else if (ir_op == OP_RSV6 || ir_op == OP_RSV7) st_d = ST_DONE;
        else                                           st_d = ST_READ;
      end
      ST_READ: begin
        ctl.mem_rd = 1'b1;
        st_d       = ST_CAPT;
      end
      ST_CAPT: begin
        ctl.ld_mbr_mem = 1'b1;
        st_d           = ST_OPND;
      end
      ST_OPND: begin
        ctl.drv[DRV_MBR] = 1'b1;
        ctl.ld_y         = 1'b1;
        st_d             = ST_CALC;
      end
      ST_CALC: begin
        ctl.drv[DRV_AC] = 1'b1;
        ctl.ld_z        = 1'b1;
        ctl.fn          = fn_of(ir_op);
        st_d            = ST_WBAC;
      end
      ST_WBAC: begin
        ctl.drv[DRV_Z] = 1'b1;
        ctl.ld_ac      = 1'b1;
        st_d           = ST_DONE;
      end
      ST_SMBR: begin
        ctl.drv[DRV_AC] = 1'b1;
        ctl.ld_mbr_bus  = 1'b1;
        st_d            = ST_WRITE;
      end
      ST_WRITE: begin
        ctl.mem_we = 1'b1;
        st_d       = ST_DONE;
      end
      ST_DONE: begin
        ctl.done = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.done |=> !ctl.done)
    else $error("R9: done wider than one cycle");

  p_read_then_capture_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.mem_rd |=> ctl.ld_mbr_mem)
    else $error("R12: read data not captured the next cycle");

endmodule

// File: rtl/sbd_top.sv
module sbd_top
  import sbd_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [OPW+AW-1:0] instr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DW-1:0]     ac_o,
  output logic              bus_err_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i
);

  localparam int IRW = OPW + AW;

  logic [1:0]     rst_sync_q;
  logic           rst_q;
  logic [IRW-1:0] ir_q;
  logic [AW-1:0]  mar_q;
  logic [DW-1:0]  mbr_q, y_q, z_q, ac_q;
  logic           err_q;
  logic [DW-1:0]  ir_addr_ext;
  logic [DW-1:0]  bus, alu_res;
  logic           conflict;
  op_e            ir_op;
  ctrl_t          ctl;
  logic [NDRV-1:0][DW-1:0] src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  assign ir_op = op_e'(ir_q[IRW-1:AW]);

  always_comb begin
    ir_addr_ext         = '0;
    ir_addr_ext[AW-1:0] = ir_q[AW-1:0];
  end

  assign src[DRV_IR]  = ir_addr_ext;
  assign src[DRV_MBR] = mbr_q;
  assign src[DRV_AC]  = ac_q;
  assign src[DRV_Z]   = z_q;

  sbd_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_q),
    .start_i (start_i),
    .ir_op   (ir_op),
    .ctl     (ctl)
  );

  sbd_bus #(.DW(DW), .N(NDRV)) u_bus (
    .clk      (clk),
    .rst_n    (rst_q),
    .en       (ctl.drv),
    .src      (src),
    .bus      (bus),
    .conflict (conflict)
  );

  sbd_alu #(.DW(DW)) u_alu (
    .fn     (ctl.fn),
    .bus_in (bus),
    .y_in   (y_q),
    .res    (alu_res)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ir_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      y_q   <= '0;
      z_q   <= '0;
      ac_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (ctl.ld_ir)      ir_q  <= instr_i;
      if (ctl.ld_mar)     mar_q <= bus[AW-1:0];
      if (ctl.ld_mbr_mem) mbr_q <= mem_rdata_i;
      else if (ctl.ld_mbr_bus) mbr_q <= bus;
      if (ctl.ld_y)       y_q   <= bus;
      if (ctl.ld_z)       z_q   <= alu_res;
      if (ctl.ld_ac)      ac_q  <= bus;
      if (conflict)       err_q <= 1'b1;
    end
  end

  assign busy_o      = ctl.busy;
  assign done_o      = ctl.done;
  assign ac_o        = ac_q;
  assign bus_err_o   = err_q;
  assign mem_addr_o  = mar_q;
  assign mem_rd_o    = ctl.mem_rd;
  assign mem_we_o    = ctl.mem_we;
  assign mem_wdata_o = mbr_q;

  p_rd_addr_r12: assert property (@(posedge clk) disable iff (!rst_q)
    mem_rd_o |-> (mem_addr_o == ir_q[AW-1:0]))
    else $error("R12: read address differs from address field");

  p_done_after_ac_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (done_o && (ir_op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_LOAD}))
      |-> $past(ctl.ld_ac))
    else $error("R9: done not preceded by accumulator load");

  p_store_keeps_ac_r6: assert property (@(posedge clk) disable iff (!rst_q)
    mem_we_o |=> $stable(ac_q))
    else $error("R6: accumulator changed during store");

  p_ir_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (busy_o && start_i) |=> $stable(ir_q))
    else $error("R10: instruction register reloaded while busy");

  p_no_bus_err_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !bus_err_o)
    else $error("R11: bus conflict flagged");

endmodule

// File: tb/sbd_top_tb.sv
`timescale 1ns/1ps
module sbd_top_tb;

  localparam int DW  = 8;
  localparam int AW  = 4;
  localparam int IRW = 3 + AW;
  localparam int MD  = 1 << AW;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start_i;
  logic [IRW-1:0] instr_i;
  logic           busy_o, done_o, bus_err_o, mem_rd_o, mem_we_o;
  logic [DW-1:0]  ac_o, mem_wdata_o, mem_rdata_i;
  logic [AW-1:0]  mem_addr_o;

  logic [DW-1:0]  mem [MD];
  int             rd_total;
  int             wr_total;
  int             checks;
  int             errors;
  int             cyc;
  logic [DW-1:0]  model_ac;

  always #2.5 clk = ~clk;

  sbd_top #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
    .busy_o(busy_o), .done_o(done_o), .ac_o(ac_o), .bus_err_o(bus_err_o),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [DW-1:0] init_word(int i);
    return DW'((i * 53 + 29) & 8'hFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MD; i++) mem[i] <= init_word(i);
      mem_rdata_i <= '0;
      rd_total    <= 0;
      wr_total    <= 0;
    end else begin
      if (mem_rd_o) begin
        mem_rdata_i <= mem[mem_addr_o];
        rd_total    <= rd_total + 1;
      end
      if (mem_we_o) begin
        mem[mem_addr_o] <= mem_wdata_o;
        wr_total        <= wr_total + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a,
                        input bit hold, input logic [IRW-1:0] alt);
    logic [DW-1:0] m, exp_ac;
    int rd0, wr0, n, exp_n;
    string rq;
    m   = mem[a];
    rd0 = rd_total;
    wr0 = wr_total;
    @(negedge clk);
    start_i = 1'b1;
    instr_i = {op, a};
    @(posedge clk);
    @(negedge clk);
    if (!hold) start_i = 1'b0;
    else       instr_i = alt;
    n = 1;
    while (!done_o && n < 40) begin
      @(negedge clk);
      n++;
    end
    exp_n = (op <= 3'd4) ? 7 : (op == 3'd5) ? 4 : 2;
    chk(n == exp_n, "R8", "done latency", n, exp_n);
    @(negedge clk);
    start_i = 1'b0;
    chk(!done_o, "R9", "done width", int'(done_o), 0);
    chk(!busy_o, "R10", "busy after done", int'(busy_o), 0);
    unique case (op)
      3'd0: begin exp_ac = model_ac + m; rq = "R2"; end
      3'd1: begin exp_ac = model_ac - m; rq = "R3"; end
      3'd2: begin exp_ac = model_ac & m; rq = "R4"; end
      3'd3: begin exp_ac = model_ac | m; rq = "R4"; end
      3'd4: begin exp_ac = m;            rq = "R5"; end
      3'd5: begin exp_ac = model_ac;     rq = "R6"; end
      default: begin exp_ac = model_ac;  rq = "R7"; end
    endcase
    chk(ac_o == exp_ac, rq, "accumulator", int'(ac_o), int'(exp_ac));
    if (op == 3'd5) begin
      chk(mem[a] == model_ac, "R6", "stored word", int'(mem[a]), int'(model_ac));
      chk(wr_total - wr0 == 1, "R6", "write count", wr_total - wr0, 1);
    end else begin
      chk(mem[a] == m, "R7", "memory untouched", int'(mem[a]), int'(m));
      chk(wr_total == wr0, "R7", "no write", wr_total - wr0, 0);
    end
    chk(rd_total - rd0 == ((op <= 3'd4) ? 1 : 0), "R12", "read count",
        rd_total - rd0, (op <= 3'd4) ? 1 : 0);
    chk(!bus_err_o, "R11", "bus error flag", int'(bus_err_o), 0);
    model_ac = exp_ac;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [DW-1:0] keep9;
    int rd0;
    checks   = 0;
    errors   = 0;
    model_ac = '0;
    start_i  = 1'b0;
    instr_i  = '0;
    rst_n    = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ac_o == '0, "R1", "reset accumulator", int'(ac_o), 0);
    chk(!busy_o && !done_o, "R1", "reset busy/done", int'(busy_o | done_o), 0);
    chk(!bus_err_o && !mem_rd_o && !mem_we_o, "R1", "reset strobes",
        int'(bus_err_o | mem_rd_o | mem_we_o), 0);

    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < MD; a++) begin
        run_op(3'd4, AW'((a + 5) % MD), 1'b0, '0);
        run_op(3'(op), AW'(a), 1'b0, '0);
      end
    end

    // R10: request held through an add while instr_i switches to a store
    keep9 = mem[9];
    rd0   = rd_total;
    run_op(3'd0, AW'(3), 1'b1, {3'd5, 4'd9});
    repeat (4) @(negedge clk);
    chk(!busy_o, "R10", "no second accept", int'(busy_o), 0);
    chk(mem[9] == keep9, "R10", "held store ignored", int'(mem[9]), int'(keep9));
    chk(rd_total - rd0 == 1, "R10", "single read", rd_total - rd0, 1);
    chk(ac_o == model_ac, "R10", "accumulator after hold", int'(ac_o), int'(model_ac));

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule